// File: doc/BRIEF.md
# Cache-Line Block Transfer Engine

This block moves memory whole cache lines at a time. Software programs a source address, a destination address and an optional notification address, then issues a single control write. That write carries the start flag, the mode bits and the line count. The engine then walks the lines in ascending address order. It keeps one memory request outstanding at a time on a line-wide request/response port. In copy mode each line is read from the source and written to the destination. In zero-fill mode no reads are issued and every destination line is written with zeros.

When a job completes cleanly and notification was requested, the engine writes one line to the notification address. It stays busy until that write is acknowledged. A bad memory response or a missing response ends the job at once. The status word then holds an error flag, a six-bit cause code and the number of lines still left. A job whose addresses are not line-aligned is refused before any memory traffic.

Top module: `line_xfer_engine`

## Requirements
- R1: Register select 1, 2 and 3 hold the source, destination and notification addresses and read back as written. Select 0 reads the status word with these fields: remaining lines in bits 15:0, busy in bit 16, error in bit 17, zero-fill in bit 24, notify in bit 28, cause in bits 41:36. All other status bits read zero.
- R2: A write to select 0 with bit 16 set while the engine is idle starts a job. The job takes its line count from bits 15:0, zero-fill from bit 24 and notify from bit 28. It ignores bits 25-27 and 29-31, which read back as zero. A start clears any earlier error flag and cause.
- R3: In copy mode, line i is read from source + i*LB and then written to destination + i*LB, where LB is the line size in bytes. Lines go in ascending order, with exactly one read and one write per line.
- R4: In zero-fill mode no read is issued, and each destination line is written with an all-zero line.
- R5: With notify set and no error, exactly one write follows the last line. It goes to the notification address and carries the job's line count in its low 16 bits, with zeros above. Busy stays set until that write is acknowledged.
- R6: A job with a line count of zero moves no lines. With notify set it makes only the notification write. Without notify it ends with no memory request, busy clear and no error.
- R7: A misaligned start is refused without any memory request. Misaligned means any of the low log2(LB) address bits is set in the destination, in the source (copy mode only) or in the notification address (when notify is set). The refusal sets the error flag with cause 0x08 and leaves the remaining count equal to the requested count.
- R8: A response with a nonzero error code ends the job at once and issues no further request. Busy clears, the error flag sets and the cause takes that code. The remaining count includes the line whose access failed.
- R9: A request that has waited timeout_cycles cycles without a response is dropped, and the job ends with cause 0x10. A response arriving in the last allowed cycle is accepted normally.
- R10: A start write that arrives while busy is ignored, and the running job continues unchanged.
- R11: Once raised, the memory request keeps its address, direction and write data until it is answered or times out.
- R12: After reset the status word reads zero and no memory request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control/status, 1 source, 2 destination, 3 notification |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data of the selected register (combinational) |
| timeout_cycles | input | 16 | Cycles a request may wait for its response |
| mem_req | output | 1 | Memory request valid, held until answered |
| mem_we | output | 1 | 1 for a line write, 0 for a line read |
| mem_addr | output | 32 | Byte address of the line |
| mem_wdata | output | 64 | Line write data |
| mem_rsp_valid | input | 1 | Response for the current request |
| mem_rsp_err | input | 6 | Error code of the response, 0 when good |
| mem_rsp_data | input | 64 | Read line data |

## Verification
The timeout check and the arrival of a response can land in the same cycle: the last cycle a request may wait is also a cycle where its response can be accepted. The bench provokes this by setting the memory latency one cycle below the limit and then equal to it. The first setting must finish the job with no error. The second must end it with cause 0x10, no line written and the full count remaining. A second collision, a start write landing on a running job, is judged by reading the status in the next cycle and by checking the final memory image.

// File: rtl/lxe_pkg.sv
package lxe_pkg;

  localparam int REG_W     = 64;
  localparam int LEN_W     = 16;
  localparam int CAUSE_W   = 6;
  localparam int BIT_BUSY  = 16;
  localparam int BIT_ERR   = 17;
  localparam int BIT_ZF    = 24;
  localparam int BIT_NTF   = 28;
  localparam int CAUSE_LSB = 36;

  localparam logic [CAUSE_W-1:0] CAUSE_ACCESS = 6'h08;
  localparam logic [CAUSE_W-1:0] CAUSE_TMO    = 6'h10;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_NOTE} st_e;

  typedef struct packed {
    logic             zf;
    logic             ntf;
    logic [LEN_W-1:0] lines;
  } job_t;

  // true when the low off_bits of the address are all zero
  function automatic logic line_ok(input logic [63:0] a, input int unsigned off_bits);
    logic [63:0] m;
    m = (64'd1 << off_bits) - 64'd1;
    return (a & m) == 64'd0;
  endfunction

  function automatic logic job_misaligned(input job_t j, input logic [63:0] s,
                                          input logic [63:0] d, input logic [63:0] n,
                                          input int unsigned off_bits);
    return (!j.zf && !line_ok(s, off_bits)) || !line_ok(d, off_bits) ||
           (j.ntf && !line_ok(n, off_bits));
  endfunction

  function automatic st_e first_state(input job_t j);
    if (j.lines == '0) return j.ntf ? ST_NOTE : ST_IDLE;
    return j.zf ? ST_WRITE : ST_READ;
  endfunction

  function automatic st_e after_line(input job_t j, input logic last);
    if (last) return j.ntf ? ST_NOTE : ST_IDLE;
    return j.zf ? ST_WRITE : ST_READ;
  endfunction

  function automatic logic [REG_W-1:0] status_word(input logic busy, input logic err,
                                                   input logic [CAUSE_W-1:0] cause,
                                                   input logic zf, input logic ntf,
                                                   input logic [LEN_W-1:0] rem);
    logic [REG_W-1:0] w;
    w = '0;
    w[LEN_W-1:0] = rem;
    w[BIT_BUSY] = busy;
    w[BIT_ERR] = err;
    w[BIT_ZF] = zf;
    w[BIT_NTF] = ntf;
    w[CAUSE_LSB +: CAUSE_W] = cause;
    return w;
  endfunction

endpackage

// File: rtl/lxe_regs.sv
module lxe_regs
  import lxe_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              busy,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [ADDR_W-1:0] note_q,
  output logic              start,
  output job_t              start_job
);

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_sel == 2'd0);
  assign start   = ctrl_wr && wr_data[BIT_BUSY] && !busy;

  assign start_job.zf    = wr_data[BIT_ZF];
  assign start_job.ntf   = wr_data[BIT_NTF];
  assign start_job.lines = wr_data[LEN_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      note_q <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd1:    src_q  <= wr_data[ADDR_W-1:0];
        2'd2:    dst_q  <= wr_data[ADDR_W-1:0];
        2'd3:    note_q <= wr_data[ADDR_W-1:0];
        default: ;
      endcase
    end
  end

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data;

endmodule

// File: rtl/lxe_timer.sv
module lxe_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             waiting,
  input  logic             answered,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] wait_cnt;

  assign expired = waiting && !answered && (wait_cnt == limit - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_cnt <= '0;
    end else if (!waiting || answered || expired) begin
      wait_cnt <= '0;
    end else begin
      wait_cnt <= wait_cnt + ONE;
    end
  end

endmodule

// File: rtl/lxe_seq.sv
module lxe_seq
  import lxe_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  job_t               start_job,
  input  logic [ADDR_W-1:0]  src_in,
  input  logic [ADDR_W-1:0]  dst_in,
  input  logic [ADDR_W-1:0]  note_in,
  input  logic               rsp_valid,
  input  logic [CAUSE_W-1:0] rsp_err,
  input  logic [LINE_W-1:0]  rsp_data,
  input  logic               tmo,
  output logic               req,
  output logic               we,
  output logic [ADDR_W-1:0]  addr,
  output logic [LINE_W-1:0]  wdata,
  output logic               busy,
  output logic               err_q,
  output logic [CAUSE_W-1:0] cause_q,
  output job_t               job_q,
  output logic [LEN_W-1:0]   remain_q,
  output logic               in_note,
  output logic               ev_fail,
  output logic               ev_reject,
  output logic               ev_line_done
);

  localparam int LINE_BYTES = LINE_W / 8;
  localparam int unsigned OFF_BITS = $clog2(LINE_BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(LINE_BYTES);
  localparam logic [LEN_W-1:0] ONE_LINE = LEN_W'(1);

  st_e               st;
  logic [ADDR_W-1:0] src_a, dst_a, note_a;
  logic [LINE_W-1:0] line_q;
  logic              rsp_bad, ev_ok;
  logic [CAUSE_W-1:0] fail_code;

  assign req     = (st != ST_IDLE);
  assign busy    = req;
  assign in_note = (st == ST_NOTE);
  assign we      = (st != ST_READ);

  always_comb begin
    case (st)
      ST_READ:  addr = src_a;
      ST_NOTE:  addr = note_a;
      default:  addr = dst_a;
    endcase
  end

  always_comb begin
    if (st == ST_NOTE)   wdata = {{(LINE_W-LEN_W){1'b0}}, job_q.lines};
    else if (job_q.zf)   wdata = '0;
    else                 wdata = line_q;
  end

  assign rsp_bad   = rsp_valid && (rsp_err != '0);
  assign ev_ok     = req && rsp_valid && !rsp_bad;
  assign ev_fail   = req && (rsp_bad || tmo);
  assign fail_code = rsp_bad ? rsp_err : CAUSE_TMO;
  assign ev_line_done = ev_ok && (st == ST_WRITE);
  assign ev_reject = start && job_misaligned(start_job, 64'(src_in), 64'(dst_in),
                                             64'(note_in), OFF_BITS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      src_a    <= '0;
      dst_a    <= '0;
      note_a   <= '0;
      line_q   <= '0;
      job_q    <= '0;
      remain_q <= '0;
      err_q    <= 1'b0;
      cause_q  <= '0;
    end else if (start) begin
      job_q    <= start_job;
      remain_q <= start_job.lines;
      src_a    <= src_in;
      dst_a    <= dst_in;
      note_a   <= note_in;
      if (ev_reject) begin
        st      <= ST_IDLE;
        err_q   <= 1'b1;
        cause_q <= CAUSE_ACCESS;
      end else begin
        st      <= first_state(start_job);
        err_q   <= 1'b0;
        cause_q <= '0;
      end
    end else if (ev_fail) begin
      st      <= ST_IDLE;
      err_q   <= 1'b1;
      cause_q <= fail_code;
    end else if (ev_ok) begin
      case (st)
        ST_READ: begin
          line_q <= rsp_data;
          st     <= ST_WRITE;
        end
        ST_WRITE: begin
          remain_q <= remain_q - ONE_LINE;
          src_a    <= src_a + STEP;
          dst_a    <= dst_a + STEP;
          st       <= after_line(job_q, remain_q == ONE_LINE);
        end
        ST_NOTE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/line_xfer_engine.sv
module line_xfer_engine
  import lxe_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 64,
  parameter int TMO_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [1:0]         reg_sel,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [TMO_W-1:0]   timeout_cycles,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [LINE_W-1:0]  mem_wdata,
  input  logic               mem_rsp_valid,
  input  logic [CAUSE_W-1:0] mem_rsp_err,
  input  logic [LINE_W-1:0]  mem_rsp_data
);

  logic [ADDR_W-1:0]  src_q, dst_q, note_q;
  logic               ev_start, ev_fail, ev_reject, ev_line_done, ev_tmo;
  logic               busy, err_flag, in_note, run_zf;
  logic [CAUSE_W-1:0] cause;
  logic [LEN_W-1:0]   remain;
  job_t               start_job, job_q;

  lxe_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_sel(reg_sel), .wr_data(reg_wdata),
    .busy(busy), .src_q(src_q), .dst_q(dst_q), .note_q(note_q),
    .start(ev_start), .start_job(start_job)
  );

  lxe_timer #(.CNT_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .waiting(mem_req), .answered(mem_rsp_valid),
    .limit(timeout_cycles), .expired(ev_tmo)
  );

  lxe_seq #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(ev_start), .start_job(start_job),
    .src_in(src_q), .dst_in(dst_q), .note_in(note_q),
    .rsp_valid(mem_rsp_valid), .rsp_err(mem_rsp_err), .rsp_data(mem_rsp_data),
    .tmo(ev_tmo), .req(mem_req), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata),
    .busy(busy), .err_q(err_flag), .cause_q(cause), .job_q(job_q), .remain_q(remain),
    .in_note(in_note), .ev_fail(ev_fail), .ev_reject(ev_reject), .ev_line_done(ev_line_done)
  );

  assign run_zf = job_q.zf;

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = status_word(busy, err_flag, cause, job_q.zf, job_q.ntf, remain);
      2'd1:    reg_rdata = REG_W'(src_q);
      2'd2:    reg_rdata = REG_W'(dst_q);
      default: reg_rdata = REG_W'(note_q);
    endcase
  end

endmodule

// File: rtl/lxe_chk.sv
module lxe_chk #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_sel,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LINE_W-1:0] mem_wdata,
  input logic              mem_rsp_valid,
  input logic              busy,
  input logic              err_flag,
  input logic [5:0]        cause,
  input logic [15:0]       remain,
  input logic              in_note,
  input logic              run_zf,
  input logic              ev_fail,
  input logic              ev_reject,
  input logic              ev_tmo,
  input logic              ev_line_done
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rsp_valid && !ev_tmo |=> mem_req && $stable(mem_addr) &&
    $stable(mem_we) && $stable(mem_wdata)); // R11

  AST_ZF_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && run_zf |-> mem_we); // R4

  AST_ZF_ZERO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && run_zf && !in_note |-> mem_wdata == '0); // R4

  AST_FAIL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fail |=> !mem_req && err_flag); // R8

  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> cause != 6'd0); // R8

  AST_TMO_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tmo |=> !mem_req && cause == 6'h10); // R9

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> !mem_req && err_flag && cause == 6'h08); // R7

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_wr && reg_sel == 2'd0 && !mem_rsp_valid && !ev_tmo |=>
    mem_req && $stable(mem_addr) && $stable(remain)); // R10

  AST_NOTE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    in_note |-> remain == 16'd0 && mem_we); // R5

  AST_LINE_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_line_done |=> remain == $past(remain) - 16'd1); // R3

endmodule

bind line_xfer_engine lxe_chk #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_rsp_valid(mem_rsp_valid), .busy(busy), .err_flag(err_flag), .cause(cause),
  .remain(remain), .in_note(in_note), .run_zf(run_zf), .ev_fail(ev_fail),
  .ev_reject(ev_reject), .ev_tmo(ev_tmo), .ev_line_done(ev_line_done)
);

// File: tb/line_xfer_engine_tb.sv
module line_xfer_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [15:0] timeout_cycles = 16'd8;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [5:0]  mem_rsp_err = '0;
  logic [63:0] mem_rsp_data = '0;

  always #10 clk = ~clk;

  line_xfer_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .timeout_cycles(timeout_cycles), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data)
  );

  localparam logic [31:0] NOTE_ADDR = 32'h1F0; // line 62

  int checks = 0;
  int errors = 0;

  // memory model state
  logic [63:0] mem [64];
  int  lat = 0;
  bit  hang = 0;
  int  acc_n = 0, rd_n = 0, wr_n = 0, order_bad = 0;
  int  err_at = -1;
  logic [5:0] err_code = '0;
  logic [7:0] j_mode = '0;
  int  j_cnt = 0;
  logic [31:0] j_src = '0, j_dst = '0;

  function automatic logic [63:0] init_val(input int i);
    return 64'hC0DE_0000_0000_0000 | (64'(i) << 32) | 64'(i * 7 + 3);
  endfunction

  function automatic logic [63:0] st_exp(input bit busy, input bit err, input int cause,
                                         input bit zf, input bit ntf, input int rem);
    return (64'(cause) << 36) | (64'(ntf) << 28) | (64'(zf) << 24) |
           (64'(err) << 17) | (64'(busy) << 16) | 64'(rem & 16'hFFFF);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int i = 0; i < 64; i++) mem[i] = init_val(i);
  endtask

  task automatic serve();
    bit ew;
    logic [31:0] ea;
    int idx;
    idx = int'(mem_addr[8:3]);
    if (j_mode[0]) begin
      ew = 1'b1;
      ea = (acc_n < j_cnt) ? j_dst + 32'(acc_n * 8) : NOTE_ADDR;
    end else if (acc_n < 2 * j_cnt) begin
      ew = (acc_n % 2) == 1;
      ea = ew ? j_dst + 32'((acc_n / 2) * 8) : j_src + 32'((acc_n / 2) * 8);
    end else begin
      ew = 1'b1;
      ea = NOTE_ADDR;
    end
    if (ew != mem_we || ea != mem_addr) order_bad++;
    if (mem_we) wr_n++; else rd_n++;
    if (acc_n == err_at) begin
      mem_rsp_err = err_code;
    end else if (mem_we) begin
      mem[idx] = mem_wdata;
    end else begin
      mem_rsp_data = mem[idx];
    end
    acc_n++;
    mem_rsp_valid = 1'b1;
  endtask

  initial begin
    int k;
    k = 0;
    forever begin
      @(negedge clk);
      if (mem_rsp_valid) begin
        mem_rsp_valid = 1'b0;
        mem_rsp_err = '0;
        k = 0;
      end
      if (mem_req && !hang) begin
        if (k == lat) serve();
        k++;
      end else begin
        k = 0;
      end
    end
  end

  task automatic reg_write(input logic [1:0] sel, input logic [63:0] d);
    reg_sel = sel;
    reg_wdata = d;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [63:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [63:0] s;
    for (int n = 0; n < 3000; n++) begin
      reg_read(2'd0, s);
      if (!s[16]) break;
      @(negedge clk);
    end
  endtask

  task automatic launch(input logic [7:0] mode, input int cnt, input logic [31:0] src,
                        input logic [31:0] dst);
    j_mode = mode; j_cnt = cnt; j_src = src; j_dst = dst;
    acc_n = 0; rd_n = 0; wr_n = 0; order_bad = 0;
    reg_write(2'd1, 64'(src));
    reg_write(2'd2, 64'(dst));
    reg_write(2'd3, 64'(NOTE_ADDR));
    reg_write(2'd0, (64'(mode) << 24) | (64'd1 << 16) | 64'(cnt));
  endtask

  // count lines differing from the expected image; done = lines completed
  function automatic int image_bad(input bit zf, input bit ntf, input int cnt,
                                   input int src_ln, input int dst_ln, input int done);
    logic [63:0] e;
    int bad;
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      e = init_val(i);
      if (i >= dst_ln && i < dst_ln + done) e = zf ? 64'd0 : init_val(src_ln + i - dst_ln);
      if (ntf && i == 62) e = 64'(cnt);
      if (mem[i] !== e) bad++;
    end
    return bad;
  endfunction

  typedef struct packed {
    logic [7:0]  mode;
    logic [15:0] cnt;
    logic [5:0]  src_ln;
    logic [5:0]  dst_ln;
    logic [3:0]  lat;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{8'h00, 16'd4, 6'd0,  6'd16, 4'd0},
    '{8'h10, 16'd3, 6'd4,  6'd24, 4'd2},
    '{8'h01, 16'd5, 6'd0,  6'd32, 4'd1},
    '{8'h11, 16'd2, 6'd0,  6'd40, 4'd0},
    '{8'h10, 16'd1, 6'd8,  6'd44, 4'd3},
    '{8'hEE, 16'd6, 6'd10, 6'd48, 4'd1},
    '{8'hEF, 16'd2, 6'd0,  6'd56, 4'd2}
  };

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] s;
    init_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset state
    reg_read(2'd0, s);
    chk("R12 status after reset", s, 64'd0);
    chk("R12 no request after reset", 64'(mem_req), 64'd0);

    // R1: address registers read back
    reg_write(2'd1, 64'h0000_0000_1234_5678);
    reg_write(2'd2, 64'h0000_0000_0BAD_CAFE);
    reg_write(2'd3, 64'h0000_0000_0000_0FC0);
    reg_read(2'd1, s); chk("R1 source readback", s, 64'h1234_5678);
    reg_read(2'd2, s); chk("R1 destination readback", s, 64'h0BAD_CAFE);
    reg_read(2'd3, s); chk("R1 notify readback", s, 64'h0FC0);

    // table of jobs: R2 R3 R4 R5
    for (int v = 0; v < 7; v++) begin
      bit zf, ntf;
      zf = VECS[v].mode[0];
      ntf = VECS[v].mode[4];
      init_mem();
      lat = int'(VECS[v].lat);
      launch(VECS[v].mode, int'(VECS[v].cnt), 32'(VECS[v].src_ln) * 8, 32'(VECS[v].dst_ln) * 8);
      wait_idle();
      reg_read(2'd0, s);
      chk("R2 status after job", s, st_exp(0, 0, 0, zf, ntf, 0));
      chk(zf ? "R4 memory image" : "R3 memory image",
          64'(image_bad(zf, ntf, int'(VECS[v].cnt), int'(VECS[v].src_ln),
                        int'(VECS[v].dst_ln), int'(VECS[v].cnt))), 64'd0);
      chk(zf ? "R4 read count" : "R3 read count", 64'(rd_n), zf ? 64'd0 : 64'(VECS[v].cnt));
      chk("R5 write count", 64'(wr_n), 64'(VECS[v].cnt) + 64'(ntf));
      chk("R3 access order", 64'(order_bad), 64'd0);
    end

    // R2 R6: ignored mode bits with zero count, no notify
    init_mem();
    lat = 0;
    launch(8'hEE, 0, 32'h0, 32'h80);
    @(negedge clk);
    reg_read(2'd0, s);
    chk("R2 ignored mode bits", s, st_exp(0, 0, 0, 0, 0, 0));
    chk("R6 zero count no traffic", 64'(acc_n), 64'd0);

    // R5 R6: zero count with notify, busy held until acknowledged
    init_mem();
    lat = 5;
    launch(8'h10, 0, 32'h0, 32'h80);
    reg_read(2'd0, s);
    chk("R5 busy during notify write", s, st_exp(1, 0, 0, 0, 1, 0));
    chk("R6 notify address only", 64'(mem_addr), 64'(NOTE_ADDR));
    wait_idle();
    reg_read(2'd0, s);
    chk("R5 status after notify", s, st_exp(0, 0, 0, 0, 1, 0));
    chk("R6 single access", 64'(acc_n), 64'd1);
    chk("R5 notify word", mem[62], 64'd0);

    // R7: misaligned source (copy) and destination (zero-fill)
    init_mem();
    lat = 0;
    launch(8'h00, 3, 32'h104, 32'h100);
    @(negedge clk);
    reg_read(2'd0, s);
    chk("R7 misaligned source", s, st_exp(0, 1, 8, 0, 0, 3));
    chk("R7 no access", 64'(acc_n), 64'd0);
    launch(8'h01, 2, 32'h0, 32'h10C);
    @(negedge clk);
    reg_read(2'd0, s);
    chk("R7 misaligned destination", s, st_exp(0, 1, 8, 1, 0, 2));
    chk("R7 no access zero-fill", 64'(acc_n), 64'd0);

    // R8: error response on the second line's write
    init_mem();
    lat = 0;
    err_at = 3;
    err_code = 6'h04;
    launch(8'h00, 4, 32'h0, 32'h80);
    wait_idle();
    repeat (3) @(negedge clk);
    reg_read(2'd0, s);
    chk("R8 error status", s, st_exp(0, 1, 4, 0, 0, 3));
    chk("R8 no access after error", 64'(acc_n), 64'd4);
    chk("R8 memory image", 64'(image_bad(0, 0, 4, 0, 16, 1)), 64'd0);
    err_at = -1;

    // R9: no response at all
    init_mem();
    hang = 1;
    launch(8'h00, 2, 32'h0, 32'h80);
    wait_idle();
    reg_read(2'd0, s);
    chk("R9 timeout status", s, st_exp(0, 1, 16, 0, 0, 2));
    chk("R9 request dropped", 64'(mem_req), 64'd0);
    hang = 0;

    // R9: response in the last allowed cycle, then one cycle too late
    init_mem();
    lat = 7;
    launch(8'h00, 2, 32'h20, 32'h100);
    wait_idle();
    reg_read(2'd0, s);
    chk("R9 last-cycle response accepted", s, st_exp(0, 0, 0, 0, 0, 0));
    chk("R9 last-cycle image", 64'(image_bad(0, 0, 2, 4, 32, 2)), 64'd0);
    init_mem();
    lat = 8;
    launch(8'h00, 2, 32'h20, 32'h100);
    wait_idle();
    reg_read(2'd0, s);
    chk("R9 late response times out", s, st_exp(0, 1, 16, 0, 0, 2));
    chk("R9 late image untouched", 64'(image_bad(0, 0, 2, 4, 32, 0)), 64'd0);
    repeat (12) @(negedge clk);

    // R10: start while busy is ignored
    init_mem();
    lat = 3;
    launch(8'h00, 3, 32'hA0, 32'hF0);
    reg_write(2'd0, (64'h01 << 24) | (64'd1 << 16) | 64'd9);
    reg_read(2'd0, s);
    chk("R10 status after ignored start", s, st_exp(1, 0, 0, 0, 0, 3));
    wait_idle();
    reg_read(2'd0, s);
    chk("R10 first job completes", s, st_exp(0, 0, 0, 0, 0, 0));
    chk("R10 memory image", 64'(image_bad(0, 0, 3, 20, 30, 3)), 64'd0);
    chk("R10 write count", 64'(wr_n), 64'd3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule